// File: doc/BRIEF.md
# General-Purpose I/O Port with Peripheral Override

This block is one 5-bit bidirectional pin port. Software controls it through a small register interface. Each pin has a stored direction bit and an output latch. Each pin also has an analog-select bit, an open-drain enable and a shutdown-select bit. On-chip peripherals can take over a pin without touching any of these stored values. A peripheral can supply its own output data. It can force the pad into output or input. While a shutdown request is high, pins that are both peripheral-driven and shutdown-selected are released to tri-state.

Software reads the pad levels through a two-flop synchroniser. Pins in analog mode read as digital zero. The direction register always returns the value software last wrote, so read-modify-write of it is safe while peripherals hold overrides. Register writes take effect on the next clock edge. Register reads are combinational from the address.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction register reads 5'h1F (all inputs) and the latch reads 0. The analog-select register reads the parameter ANALOG_RESET (default 5'h02). The open-drain and shutdown-select registers read 0, and every padOe bit is 0.
- R2: Register addresses are 0 = pin data, 1 = latch, 2 = direction, 3 = analog select, 4 = open-drain enable, 5 = shutdown select. A write to address 0 or 1 loads the latch, and address 1 reads it back. A write to addresses 2 to 5 loads that register, and the register reads back the written value.
- R3: A pin whose direction bit is 0 (output), with no override, has padOe = 1 and padOut equal to its latch bit.
- R4: When perOutEn is 1 for a pin, padOut for that pin equals perOutData rather than the latch bit.
- R5: perForceOut = 1 enables the pad driver and perForceIn = 1 disables it, whatever the direction bit is. When both are set on a pin, force-output wins.
- R6: Overrides never change the stored direction register. A read of address 2 returns the last written value.
- R7: A read of address 0 returns the pad inputs after two clock edges of synchronisation. A pin with analog select = 1 reads as 0.
- R8: Analog select does not disable the pad output driver.
- R9: A pin with open-drain enable = 1 turns padOe off when its output data is 1, and drives 0 when its output data is 0.
- R10: While shutdownReq = 1, each pin with shutdown select = 1 and perOutEn = 1 has padOe = 0. Other pins keep their normal drive.
- R11: Addresses 6 and 7 read 0. Writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address for read and write |
| regWrData | input | WIDTH | Write data |
| regRdData | output | WIDTH | Read data for regAddr (combinational) |
| perOutEn | input | WIDTH | Per pin: peripheral supplies output data |
| perOutData | input | WIDTH | Peripheral output data |
| perForceOut | input | WIDTH | Per pin: peripheral forces output drive |
| perForceIn | input | WIDTH | Per pin: peripheral forces input (driver off) |
| shutdownReq | input | 1 | Shutdown request for selected peripheral pins |
| padIn | input | WIDTH | Pad input levels (asynchronous) |
| padOe | output | WIDTH | Pad output enable |
| padOut | output | WIDTH | Pad output data |

## Verification
Some rules can be written as invariants between ports and stored state, and the checker tests them on every cycle. These are: no open-drain pin ever drives a 1, shutdown-selected peripheral pins stay released during shutdown, a pin forced to input alone is never enabled, peripheral data reaches every enabled pad where the peripheral owns the data, analog pins read zero, and the direction register changes only on its own write. The bench scenarios cover the rest. They show the reset values, the two-edge synchroniser latency, the force-output-over-force-input priority, that analog pins still drive, and that unmapped addresses ignore writes and read zero.

// File: rtl/gpio_port_pkg.sv
`timescale 1ns/1ps
package gpio_port_pkg;
  localparam int ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_PINS  = 3'd0,
    REG_LAT   = 3'd1,
    REG_DIR   = 3'd2,
    REG_ANA   = 3'd3,
    REG_ODC   = 3'd4,
    REG_SDSEL = 3'd5
  } regAddrE;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_PINS,
    RD_LAT,
    RD_DIR,
    RD_ANA,
    RD_ODC,
    RD_SDSEL
  } rdSelE;

  typedef struct packed {
    logic  wrLat;
    logic  wrDir;
    logic  wrAna;
    logic  wrOdc;
    logic  wrSdSel;
    rdSelE rdSel;
  } ctrlStrobesT;
endpackage

// File: rtl/gpio_port_ctrl.sv
`timescale 1ns/1ps
module gpio_port_ctrl
  import gpio_port_pkg::*;
(
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  output ctrlStrobesT       strb
);
  always_comb begin
    strb = '0;
    strb.rdSel = RD_NONE;
    case (regAddr)
      REG_PINS: begin
        strb.rdSel = RD_PINS;
        strb.wrLat = regWrEn;
      end
      REG_LAT: begin
        strb.rdSel = RD_LAT;
        strb.wrLat = regWrEn;
      end
      REG_DIR: begin
        strb.rdSel = RD_DIR;
        strb.wrDir = regWrEn;
      end
      REG_ANA: begin
        strb.rdSel = RD_ANA;
        strb.wrAna = regWrEn;
      end
      REG_ODC: begin
        strb.rdSel = RD_ODC;
        strb.wrOdc = regWrEn;
      end
      REG_SDSEL: begin
        strb.rdSel = RD_SDSEL;
        strb.wrSdSel = regWrEn;
      end
      default: strb.rdSel = RD_NONE;
    endcase
  end
endmodule

// File: rtl/gpio_port_datapath.sv
`timescale 1ns/1ps
module gpio_port_datapath
  import gpio_port_pkg::*;
#(
  parameter int               WIDTH        = 5,
  parameter int               SYNC_STAGES  = 2,
  parameter logic [WIDTH-1:0] ANALOG_RESET = 5'h02
)(
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobesT      strb,
  input  logic [WIDTH-1:0] regWrData,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] regRdData,
  output logic [WIDTH-1:0] dirQ,
  output logic [WIDTH-1:0] latQ,
  output logic [WIDTH-1:0] anaQ,
  output logic [WIDTH-1:0] odEnQ,
  output logic [WIDTH-1:0] sdSelQ
);
  localparam int LAST = SYNC_STAGES - 1;

  logic [WIDTH-1:0] syncQ [SYNC_STAGES];
  logic [WIDTH-1:0] pinRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirQ   <= '1;
      latQ   <= '0;
      anaQ   <= ANALOG_RESET;
      odEnQ  <= '0;
      sdSelQ <= '0;
    end else begin
      if (strb.wrDir)   dirQ   <= regWrData;
      if (strb.wrLat)   latQ   <= regWrData;
      if (strb.wrAna)   anaQ   <= regWrData;
      if (strb.wrOdc)   odEnQ  <= regWrData;
      if (strb.wrSdSel) sdSelQ <= regWrData;
    end
  end

  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ[s] <= '0;
        else if (s == 0) syncQ[s] <= padIn;
        else syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign pinRead = syncQ[LAST] & ~anaQ;

  always_comb begin
    case (strb.rdSel)
      RD_PINS:  regRdData = pinRead;
      RD_LAT:   regRdData = latQ;
      RD_DIR:   regRdData = dirQ;
      RD_ANA:   regRdData = anaQ;
      RD_ODC:   regRdData = odEnQ;
      RD_SDSEL: regRdData = sdSelQ;
      default:  regRdData = '0;
    endcase
  end
endmodule

// File: rtl/gpio_port_pinmux.sv
`timescale 1ns/1ps
module gpio_port_pinmux #(
  parameter int WIDTH = 5
)(
  input  logic [WIDTH-1:0] dirQ,
  input  logic [WIDTH-1:0] latQ,
  input  logic [WIDTH-1:0] odEnQ,
  input  logic [WIDTH-1:0] sdSelQ,
  input  logic [WIDTH-1:0] perOutEn,
  input  logic [WIDTH-1:0] perOutData,
  input  logic [WIDTH-1:0] perForceOut,
  input  logic [WIDTH-1:0] perForceIn,
  input  logic             shutdownReq,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] padOut
);
  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
      logic wantDrive;
      logic dataBit;
      logic odRelease;
      logic sdKill;

      always_comb begin
        wantDrive = perForceOut[i] | (~perForceIn[i] & ~dirQ[i]);
        dataBit   = perOutEn[i] ? perOutData[i] : latQ[i];
        odRelease = odEnQ[i] & dataBit;
        sdKill    = shutdownReq & sdSelQ[i] & perOutEn[i];
      end

      assign padOut[i] = dataBit;
      assign padOe[i]  = wantDrive & ~odRelease & ~sdKill;
    end
  endgenerate
endmodule

// File: rtl/gpio_port.sv
`timescale 1ns/1ps
module gpio_port
  import gpio_port_pkg::*;
#(
  parameter int               WIDTH        = 5,
  parameter int               SYNC_STAGES  = 2,
  parameter logic [WIDTH-1:0] ANALOG_RESET = 5'h02
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [WIDTH-1:0]  regWrData,
  output logic [WIDTH-1:0]  regRdData,
  input  logic [WIDTH-1:0]  perOutEn,
  input  logic [WIDTH-1:0]  perOutData,
  input  logic [WIDTH-1:0]  perForceOut,
  input  logic [WIDTH-1:0]  perForceIn,
  input  logic              shutdownReq,
  input  logic [WIDTH-1:0]  padIn,
  output logic [WIDTH-1:0]  padOe,
  output logic [WIDTH-1:0]  padOut
);
  ctrlStrobesT      strb;
  logic [WIDTH-1:0] dirQ;
  logic [WIDTH-1:0] latQ;
  logic [WIDTH-1:0] anaQ;
  logic [WIDTH-1:0] odEnQ;
  logic [WIDTH-1:0] sdSelQ;

  gpio_port_ctrl u_ctrl (
    .regWrEn (regWrEn),
    .regAddr (regAddr),
    .strb    (strb)
  );

  gpio_port_datapath #(
    .WIDTH        (WIDTH),
    .SYNC_STAGES  (SYNC_STAGES),
    .ANALOG_RESET (ANALOG_RESET)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .regWrData (regWrData),
    .padIn     (padIn),
    .regRdData (regRdData),
    .dirQ      (dirQ),
    .latQ      (latQ),
    .anaQ      (anaQ),
    .odEnQ     (odEnQ),
    .sdSelQ    (sdSelQ)
  );

  gpio_port_pinmux #(.WIDTH(WIDTH)) u_mux (
    .dirQ        (dirQ),
    .latQ        (latQ),
    .odEnQ       (odEnQ),
    .sdSelQ      (sdSelQ),
    .perOutEn    (perOutEn),
    .perOutData  (perOutData),
    .perForceOut (perForceOut),
    .perForceIn  (perForceIn),
    .shutdownReq (shutdownReq),
    .padOe       (padOe),
    .padOut      (padOut)
  );
endmodule

// File: rtl/gpio_port_checker.sv
`timescale 1ns/1ps
module gpio_port_checker
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 5
)(
  input logic              clk,
  input logic              rstN,
  input logic              regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [WIDTH-1:0]  regRdData,
  input logic [WIDTH-1:0]  perOutEn,
  input logic [WIDTH-1:0]  perOutData,
  input logic [WIDTH-1:0]  perForceOut,
  input logic [WIDTH-1:0]  perForceIn,
  input logic              shutdownReq,
  input logic [WIDTH-1:0]  padOe,
  input logic [WIDTH-1:0]  padOut,
  input logic [WIDTH-1:0]  dirQ,
  input logic [WIDTH-1:0]  anaQ,
  input logic [WIDTH-1:0]  odEnQ,
  input logic [WIDTH-1:0]  sdSelQ
);
  AST_PER_DATA_WINS: assert property (@(posedge clk) disable iff (!rstN)
    ((padOut ^ perOutData) & perOutEn) == '0); // R4

  AST_FORCE_IN_RELEASES: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & perForceIn & ~perForceOut) == '0); // R5

  AST_DIR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    !(regWrEn && regAddr == ADDR_W'(REG_DIR)) |=> $stable(dirQ)); // R6

  AST_ANALOG_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_W'(REG_PINS)) |-> ((regRdData & anaQ) == '0)); // R7

  AST_OD_NEVER_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & padOut & odEnQ) == '0); // R9

  AST_SHUTDOWN_TRISTATE: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |-> ((padOe & sdSelQ & perOutEn) == '0)); // R10

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr > ADDR_W'(REG_SDSEL)) |-> (regRdData == '0)); // R11
endmodule

bind gpio_port gpio_port_checker #(.WIDTH(WIDTH)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .regWrEn     (regWrEn),
  .regAddr     (regAddr),
  .regRdData   (regRdData),
  .perOutEn    (perOutEn),
  .perOutData  (perOutData),
  .perForceOut (perForceOut),
  .perForceIn  (perForceIn),
  .shutdownReq (shutdownReq),
  .padOe       (padOe),
  .padOut      (padOut),
  .dirQ        (dirQ),
  .anaQ        (anaQ),
  .odEnQ       (odEnQ),
  .sdSelQ      (sdSelQ)
);

// File: tb/gpio_port_tb.sv
`timescale 1ns/1ps
module gpio_port_tb;
  localparam int W = 5;

  typedef struct {
    string      req;
    int         kind;   // 0 read data, 1 padOe, 2 padOut
    logic [4:0] exp;
  } itemT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [2:0] regAddr = '0;
  logic [W-1:0] regWrData = '0;
  logic [W-1:0] regRdData;
  logic [W-1:0] perOutEn = '0, perOutData = '0, perForceOut = '0, perForceIn = '0;
  logic shutdownReq = 1'b0;
  logic [W-1:0] padIn = '0;
  logic [W-1:0] padOe, padOut;

  itemT scq[$];
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  gpio_port u_dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .perOutEn(perOutEn),
    .perOutData(perOutData), .perForceOut(perForceOut), .perForceIn(perForceIn),
    .shutdownReq(shutdownReq), .padIn(padIn), .padOe(padOe), .padOut(padOut)
  );

  // Monitor: pops expectations shortly after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (scq.size() > 0) begin
        itemT it;
        logic [4:0] act;
        it = scq.pop_front();
        case (it.kind)
          0: act = regRdData;
          1: act = padOe;
          default: act = padOut;
        endcase
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s kind=%0d actual=%h expected=%h", it.req, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic wrReg(input logic [2:0] a, input logic [W-1:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic expRd(input string req, input logic [2:0] a, input logic [4:0] e);
    itemT it;
    regAddr = a;
    it.req = req; it.kind = 0; it.exp = e;
    scq.push_back(it);
    @(negedge clk);
  endtask

  task automatic expPad(input string req, input logic [4:0] oe, input logic [4:0] o);
    itemT it;
    it.req = req; it.kind = 1; it.exp = oe;
    scq.push_back(it);
    it.kind = 2; it.exp = o;
    scq.push_back(it);
    @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset values
    expRd("R1 dir", 3'd2, 5'h1F);
    expRd("R1 lat", 3'd1, 5'h00);
    expRd("R1 ana", 3'd3, 5'h02);
    expRd("R1 odc", 3'd4, 5'h00);
    expRd("R1 sdsel", 3'd5, 5'h00);
    expPad("R1 pads", 5'h00, 5'h00);
    // R2 register writes
    wrReg(3'd0, 5'h15);
    expRd("R2 pins addr loads latch", 3'd1, 5'h15);
    wrReg(3'd1, 5'h0A);
    expRd("R2 latch", 3'd1, 5'h0A);
    wrReg(3'd2, 5'h1C);
    expRd("R2 dir", 3'd2, 5'h1C);
    // R3 output pins, R8 analog pin 1 still drives
    expPad("R3 latch drive", 5'h03, 5'h0A);
    expPad("R8 analog drives", 5'h03, 5'h0A);
    // R7 synchroniser latency and analog masking
    padIn = 5'h1F;
    @(negedge clk);
    expRd("R7 one edge", 3'd0, 5'h00);
    expRd("R7 two edges", 3'd0, 5'h1D);
    wrReg(3'd3, 5'h00);
    expRd("R7 analog off", 3'd0, 5'h1F);
    // R4 peripheral data priority
    perOutEn = 5'h01; perOutData = 5'h01;
    expPad("R4 per data", 5'h03, 5'h0B);
    // R5 forces
    perForceOut = 5'h10;
    expPad("R5 force out", 5'h13, 5'h0B);
    perForceIn = 5'h01;
    expPad("R5 force in", 5'h12, 5'h0B);
    perForceIn = 5'h11;
    expPad("R5 out wins", 5'h12, 5'h0B);
    expRd("R6 dir unchanged", 3'd2, 5'h1C);
    perForceOut = '0; perForceIn = '0;
    // R9 open drain
    wrReg(3'd4, 5'h03);
    expPad("R9 od release", 5'h00, 5'h0B);
    perOutData = 5'h00;
    expPad("R9 od low", 5'h01, 5'h0A);
    wrReg(3'd4, 5'h00);
    perOutData = 5'h01;
    // R10 shutdown
    wrReg(3'd5, 5'h03);
    shutdownReq = 1'b1;
    expPad("R10 shutdown", 5'h02, 5'h0B);
    shutdownReq = 1'b0;
    expPad("R10 released", 5'h03, 5'h0B);
    // R11 unmapped
    expRd("R11 read 6", 3'd6, 5'h00);
    wrReg(3'd7, 5'h1F);
    expRd("R11 dir kept", 3'd2, 5'h1C);
    expRd("R11 lat kept", 3'd1, 5'h0A);
    expRd("R11 ana kept", 3'd3, 5'h00);
    @(negedge clk);
    done = 1'b1;
    finishRun();
  end
endmodule